// File: doc/BRIEF.md
# Program Flow Sequencer with Return Stack

This block decides the next program counter for a small 24-bit signal processor that executes 16-bit opcodes. Each cycle in which an opcode is presented, the counter advances past that word. The opcode may then replace the counter with a jump target, skip the following word, return from a subroutine, or stop the machine. Calls save the address after the call on an eight-entry hardware return stack held inside the block.

The flags, the page register and the opcode come from the rest of the processor. Fetch memory, arithmetic and register writes stay outside this block. A synchronous restart input clears a halt and starts execution at a given address.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the program counter is 0, halt is clear and all eight stack entries are 0.
- R2: A cycle with `op_valid` low changes nothing. An accepted opcode that is not a taken jump, skip hit, return or halt leaves the counter at its old value plus one (the "next" value).
- R3: With mask 0xDD00, the values 0x0800, 0x0C00, 0x1000 and 0x1400 are jumps. They are taken always, when Z is set, when C is set and when N is set, respectively. An untaken jump only advances.
- R4: If opcode bit 9 is set, a taken jump goes to {page, opcode[7:0]}. If bit 9 is clear, it goes to {next[23:8], opcode[7:0]}.
- R5: If opcode bit 13 is set on a taken jump, the next value is pushed before the jump. An untaken jump pushes nothing.
- R6: A push moves every entry one place deeper, writes entry 0 and drops entry 7. After nine calls, the first call's return address is lost.
- R7: Opcode 0x3C00 loads the counter from entry 0, moves every entry one place up and writes 0 into entry 7. Returning past an empty stack yields address 0.
- R8: Opcodes 0x2500/0x2501, 0x2600/0x2601 and 0x2700/0x2701 compare C, Z and N respectively with opcode bit 0. On a match the counter becomes next plus one.
- R9: Opcode 0xFC00, or any opcode outside the defined set, sets halt with the counter at next. While halted, the counter, stack and halt stay unchanged whatever the opcode.
- R10: `restart` loads `start_addr` into the counter and clears halt, whatever the opcode in that cycle. The stack is kept.
- R11: 0x0000, 0x1C00 and every defined arithmetic, memory or move opcode only advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart at `start_addr` |
| start_addr | input | 24 | Restart address |
| op_valid | input | 1 | An opcode is presented this cycle |
| opcode | input | 16 | Current opcode |
| page | input | 16 | Page register for far jumps |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| pc | output | 24 | Program counter |
| halted | output | 1 | Halt state |
| stack_top | output | 24 | Stack entry 0 |

## Verification
The hardest case to reach is the stack edge, where the oldest return address is lost or an empty entry is popped. From the ports, only long unbroken runs of calls and returns reach it. The bench first issues nine consecutive calls to distinct pages and then ten returns. This shows the loss of the first address and the zero fill at the bottom. After that, a long random mix follows, weighted towards calls and returns, with restarts after each halt. A behavioural model with a queue stack is compared every clock.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int AW    = 24,
  parameter int PW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [AW-1:0] start_addr,
  input  logic          op_valid,
  input  logic [15:0]   opcode,
  input  logic [PW-1:0] page,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_n,
  output logic [AW-1:0] pc,
  output logic          halted,
  output logic [AW-1:0] stack_top
);
  localparam int FW = 8;

  logic [AW-1:0] stk [DEPTH];

  function automatic logic known_op(input logic [15:0] o);
    known_op = (o == 16'h0000) || (o == 16'h1C00) || (o == 16'h3C00) ||
               (o == 16'h4000) || (o == 16'h7000) || (o == 16'hFC00) ||
               ((o & 16'hDD00) inside {16'h0800, 16'h0C00, 16'h1000, 16'h1400}) ||
               ((o & 16'hFFFE) inside {16'h2500, 16'h2600, 16'h2700}) ||
               ((o & 16'hF800) inside {16'h4800, 16'h5000, 16'h8000, 16'h8800,
                                       16'h9000, 16'hA800, 16'hB000, 16'hB800}) ||
               ((o & 16'hFB00) inside {16'h5900, 16'h5A00, 16'h6000, 16'h6100,
                                       16'h6300, 16'h6800, 16'h6900, 16'h6A00,
                                       16'h9800, 16'hC000, 16'hC800, 16'hD000,
                                       16'hD800, 16'hE800, 16'hE900, 16'hEA00}) ||
               ((o & 16'hFF00) inside {16'h7C00, 16'h7D00, 16'hE000, 16'hF000});
  endfunction

  wire [AW-1:0] pc_next = pc + AW'(1);
  wire          exec    = op_valid && !halted && !restart;

  wire is_jmp = (opcode & 16'hDD00) inside {16'h0800, 16'h0C00, 16'h1000, 16'h1400};
  logic jmp_cond;
  always_comb
    case ({opcode[12], opcode[10]})
      2'b00:   jmp_cond = 1'b1;
      2'b01:   jmp_cond = flag_z;
      2'b10:   jmp_cond = flag_c;
      default: jmp_cond = flag_n;
    endcase

  wire is_skip = (opcode & 16'hFFFE) inside {16'h2500, 16'h2600, 16'h2700};
  logic skip_flag;
  always_comb
    case (opcode[9:8])
      2'b01:   skip_flag = flag_c;
      2'b10:   skip_flag = flag_z;
      default: skip_flag = flag_n;
    endcase

  wire jmp_take = exec && is_jmp && jmp_cond;
  wire do_push  = jmp_take && opcode[13];
  wire do_ret   = exec && (opcode == 16'h3C00);
  wire skip_hit = exec && is_skip && (skip_flag == opcode[0]);
  wire do_halt  = exec && ((opcode == 16'hFC00) || !known_op(opcode));

  wire [AW-1:0] far_tgt  = AW'({page, opcode[FW-1:0]});
  wire [AW-1:0] near_tgt = {pc_next[AW-1:FW], opcode[FW-1:0]};
  wire [AW-1:0] jmp_tgt  = opcode[9] ? far_tgt : near_tgt;

  assign stack_top = stk[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      halted <= 1'b0;
    end else if (restart) begin
      pc     <= start_addr;
      halted <= 1'b0;
    end else if (exec) begin
      if (jmp_take)      pc <= jmp_tgt;
      else if (do_ret)   pc <= stk[0];
      else if (skip_hit) pc <= pc_next + AW'(1);
      else               pc <= pc_next;
      if (do_halt) halted <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (do_push) begin
      stk[0] <= pc_next;
      for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
    end else if (do_ret) begin
      for (int i = 0; i < DEPTH-1; i++) stk[i] <= stk[i+1];
      stk[DEPTH-1] <= '0;
    end
  end

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> ($stable(pc) && halted && $stable(stack_top)));
  // R10
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!halted && pc == $past(start_addr)));
  // R7
  ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> (pc == $past(stack_top)));
  // R5
  call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> (stack_top == $past(pc) + AW'(1)));
  // R8
  skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_hit |=> (pc == $past(pc) + AW'(2)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !restart) |=> ($stable(pc) && $stable(halted) && $stable(stack_top)));
endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic [23:0] start_addr = '0;
  logic        op_valid = 1'b0;
  logic [15:0] opcode = '0;
  logic [15:0] page = '0;
  logic        flag_z = 1'b0, flag_c = 1'b0, flag_n = 1'b0;
  logic [23:0] pc, stack_top;
  logic        halted;

  int checks = 0;
  int fails  = 0;

  int unsigned m_pc;
  bit          m_halt;
  int unsigned m_stk[$];

  always #5 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .start_addr(start_addr),
    .op_valid(op_valid), .opcode(opcode), .page(page),
    .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n),
    .pc(pc), .halted(halted), .stack_top(stack_top)
  );

  function automatic bit is_defined(input int unsigned o);
    int unsigned mk[5]   = '{32'hDD00, 32'hFFFE, 32'hF800, 32'hFB00, 32'hFF00};
    int unsigned exact[6] = '{32'h0000, 32'h1C00, 32'h3C00, 32'h4000, 32'h7000, 32'hFC00};
    int unsigned v0[4]  = '{32'h0800, 32'h0C00, 32'h1000, 32'h1400};
    int unsigned v1[3]  = '{32'h2500, 32'h2600, 32'h2700};
    int unsigned v2[8]  = '{32'h4800, 32'h5000, 32'h8000, 32'h8800, 32'h9000, 32'hA800, 32'hB000, 32'hB800};
    int unsigned v3[16] = '{32'h5900, 32'h5A00, 32'h6000, 32'h6100, 32'h6300, 32'h6800, 32'h6900, 32'h6A00,
                            32'h9800, 32'hC000, 32'hC800, 32'hD000, 32'hD800, 32'hE800, 32'hE900, 32'hEA00};
    int unsigned v4[4]  = '{32'h7C00, 32'h7D00, 32'hE000, 32'hF000};
    foreach (exact[i]) if (o == exact[i]) return 1;
    foreach (v0[i]) if ((o & mk[0]) == v0[i]) return 1;
    foreach (v1[i]) if ((o & mk[1]) == v1[i]) return 1;
    foreach (v2[i]) if ((o & mk[2]) == v2[i]) return 1;
    foreach (v3[i]) if ((o & mk[3]) == v3[i]) return 1;
    foreach (v4[i]) if ((o & mk[4]) == v4[i]) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %06h expected %06h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "pc", pc, m_pc);
    check(tag, "halted", halted, m_halt);
    check(tag, "stack_top", stack_top, m_stk[0]);
  endtask

  // Reference: one clock of behaviour, from the requirement text.
  task automatic model(input bit v, input bit rs, input int unsigned o, input int unsigned pg,
                       input bit z, input bit c, input bit n, input int unsigned sa);
    int unsigned nx;
    bit take;
    if (rs) begin                       // R10
      m_pc = sa & 24'hFFFFFF; m_halt = 0; return;
    end
    if (!v || m_halt) return;           // R2, R9
    nx = (m_pc + 1) & 24'hFFFFFF;
    if ((o & 32'hDD00) inside {32'h0800, 32'h0C00, 32'h1000, 32'h1400}) begin   // R3
      case (o & 32'hDD00)
        32'h0800: take = 1;
        32'h0C00: take = z;
        32'h1000: take = c;
        default:  take = n;
      endcase
      if (take) begin
        if (o[13]) begin m_stk.push_front(nx); void'(m_stk.pop_back()); end  // R5, R6
        m_pc = o[9] ? (((pg & 16'hFFFF) << 8) | (o & 8'hFF)) : ((nx & 24'hFFFF00) | (o & 8'hFF)); // R4
      end else m_pc = nx;
    end else if (o == 32'h3C00) begin   // R7
      m_pc = m_stk.pop_front(); m_stk.push_back(0);
    end else if ((o & 32'hFFFE) inside {32'h2500, 32'h2600, 32'h2700}) begin     // R8
      bit f;
      f = ((o & 32'hFF00) == 32'h2500) ? c : ((o & 32'hFF00) == 32'h2600) ? z : n;
      m_pc = (f == o[0]) ? ((nx + 1) & 24'hFFFFFF) : nx;
    end else begin                      // R9, R11
      m_pc = nx;
      if (o == 32'hFC00 || !is_defined(o)) m_halt = 1;
    end
  endtask

  task automatic step(input string tag, input bit v, input bit rs, input logic [15:0] o,
                      input logic [15:0] pg, input bit z, input bit c, input bit n,
                      input logic [23:0] sa);
    op_valid = v; restart = rs; opcode = o; page = pg;
    flag_z = z; flag_c = c; flag_n = n; start_addr = sa;
    model(v, rs, o, pg, z, c, n, sa);
    @(posedge clk); #2;
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    m_pc = 0; m_halt = 0;
    for (int i = 0; i < 8; i++) m_stk.push_back(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    compare("R1");
    @(negedge clk);

    step("R2", 0, 0, 16'h0800, 16'h0000, 0, 0, 0, 0);      // R2 idle hold
    step("R10", 0, 1, 16'h0000, 16'h0000, 0, 0, 0, 24'h123456); // R10
    step("R11", 1, 0, 16'h0000, 0, 0, 0, 0, 0);            // R11 nop
    step("R11", 1, 0, 16'h1C00, 0, 0, 0, 0, 0);            // R11
    step("R11", 1, 0, 16'h8123, 0, 0, 0, 0, 0);            // R11 arithmetic
    step("R3",  1, 0, 16'h0C40, 0, 0, 1, 1, 0);            // R3 untaken zero-jump
    step("R4",  1, 0, 16'h0C40, 0, 1, 0, 0, 0);            // R3 R4 near taken
    step("R4",  1, 0, 16'h1277, 16'hABCD, 0, 1, 0, 0);     // R4 far, carry
    step("R5",  1, 0, 16'h3477, 16'h0000, 0, 0, 0, 0);     // R5 untaken call, N clear
    step("R8",  1, 0, 16'h2501, 0, 0, 1, 0, 0);            // R8 skip hit on carry
    step("R8",  1, 0, 16'h2600, 0, 1, 0, 0, 0);            // R8 no hit
    step("R8",  1, 0, 16'h2700, 0, 0, 0, 0, 0);            // R8 hit on N clear

    // R6 nine calls to distinct pages, then R7 ten returns.
    for (int k = 0; k < 9; k++)
      step("R6", 1, 0, 16'h2A00 | k[7:0], 16'(k + 1), 0, 0, 0, 0);
    for (int k = 0; k < 10; k++)
      step("R7", 1, 0, 16'h3C00, 0, 0, 0, 0, 0);

    step("R9", 1, 0, 16'hFC00, 0, 0, 0, 0, 0);             // R9 halt
    step("R9", 1, 0, 16'h2800, 0, 0, 0, 0, 0);             // R9 ignored while halted
    step("R9", 1, 0, 16'h3C00, 0, 0, 0, 0, 0);             // R9 ignored while halted
    step("R10", 1, 1, 16'h0800, 0, 0, 0, 0, 24'h000100);   // R10 restart wins
    step("R9", 1, 0, 16'h0100, 0, 0, 0, 0, 0);             // R9 undefined opcode
    step("R10", 0, 1, 16'h0000, 0, 0, 0, 0, 24'hFFFFFE);   // R10
    step("R8", 1, 0, 16'h2700, 0, 0, 0, 0, 0);             // R8 wrap at top

    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      logic [15:0] o;
      r = $urandom_range(0, 99);
      o = 16'($urandom);
      if (r < 30)      o = (o & 16'h22FF) | 16'h0800 | (16'($urandom_range(0, 3)) << 10 & 16'h1400) | 16'h2000;
      else if (r < 40) o = (o & 16'h02FF) | 16'h0800 | (16'($urandom_range(0, 3)) << 10 & 16'h1400);
      else if (r < 62) o = 16'h3C00;
      else if (r < 72) o = 16'h2500 + 16'($urandom_range(0, 2)) * 16'h0100 + 16'($urandom_range(0, 1));
      else if (r < 85) o = (o & 16'h07FF) | 16'h8000;
      if (halted && $urandom_range(0, 3) == 0)
        step("R10", 1, 1, o, 16'($urandom), 0, 0, 0, 24'($urandom));
      else
        step("R3", $urandom_range(0, 9) != 0, 0, o, 16'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule